// File: doc/BRIEF.md
# Macro Sequencer with Delay Slots

This block runs short macro programs held in a small instruction memory outside the block. A one-cycle start pulse gives it an entry address. The sequencer clears its eight-entry register file and tells the downstream stages to clear their carry flag and method address. It then loads the first word of the argument stream into register 1 and executes one 32-bit instruction per cycle until the program ends or faults. Register 0 always reads as zero.

The sequencer itself computes three kinds of instruction. Add-immediate returns source A plus a signed immediate. Read-immediate returns a word read from an external state register file at source A plus the immediate. A conditional relative branch tests source A for zero or non-zero. All other arithmetic and bitfield work is done outside the block. For those operations the sequencer presents both source registers on `op_a` and `op_b` and takes the answer back on `ext_result`. Every executed non-branch instruction puts its result, destination and assignment mode on a strobe for a separate assignment stage. The same value is written into the destination register, except in fetch mode. In fetch mode the destination takes the next argument word instead.

A taken branch can jump at once, or it can first run the next instruction as a delay slot. An instruction with the exit flag also runs one delay slot before execution ends. A branch inside a delay slot is a fault, and so is an unknown operation.

Top module: `seq_macro_core`

Instruction word: bits [2:0] operation, bit 3 exit, bits [6:4] assignment mode, bits [9:7] destination, bits [12:10] source A, bits [15:13] source B, bits [31:14] signed immediate (overlaps source B). Operations: 1 add-immediate, 4 read-immediate, 7 branch, 0/2/3/5 external, 6 unknown. For a branch, mode bit 0 (word bit 4) = 1 means branch on non-zero and 0 means branch on zero, and mode bit 1 (word bit 5) = 1 means no delay slot.

## Requirements
- R1: During and after reset, `busy`, `done`, `err`, `ctx_clear` and `res_valid` are all low.
- R2: A start pulse in idle clears every register and raises `ctx_clear` for exactly one cycle. In that cycle the head argument is popped into register 1. The first instruction executes in the following cycle.
- R3: Writes to register 0 are discarded, so register 0 always reads as zero.
- R4: Add-immediate produces source A plus the sign-extended 18-bit immediate, modulo 2^32.
- R5: Read-immediate drives `sreg_addr` = source A + immediate (low bits) and produces `sreg_data`.
- R6: A branch is taken when source A is zero (mode bit 0 = 0) or non-zero (mode bit 0 = 1). Its target is the branch's own address plus the signed immediate, which may be backward. A branch that is not taken continues in sequence.
- R7: A taken branch with mode bit 1 set jumps at once. With mode bit 1 clear, the next sequential instruction executes as a delay slot and execution then continues at the target.
- R8: A branch that executes in a delay slot raises `err`, stops execution without `done`, and produces no strobe.
- R9: An instruction with the exit bit executes the next instruction as a delay slot. `done` then pulses for one cycle, the cycle after that slot. An exit bit found inside a delay slot has no effect.
- R10: Operation code 6 raises `err` in the next cycle and stops execution.
- R11: In assignment mode 0, the destination register takes the popped argument. The strobe still carries the computed result.
- R12: Operations 0, 2, 3 and 5 present source A and source B on `op_a`/`op_b`, and their result is taken from `ext_result`.
- R13: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled in idle |
| start_pc | input | PC_W | Entry address |
| busy | output | 1 | Program loading or running |
| done | output | 1 | One-cycle pulse at normal end |
| err | output | 1 | Fault flag, held until next start |
| ctx_clear | output | 1 | Clear request for carry and method address downstream |
| imem_addr | output | PC_W | Instruction memory address |
| imem_data | input | 32 | Instruction word (combinational read) |
| arg_data | input | 32 | Head of argument FIFO |
| arg_pop | output | 1 | Argument FIFO pop |
| sreg_addr | output | SREG_AW | State register read index |
| sreg_data | input | 32 | State register read data |
| op_a | output | 32 | Source A register value |
| op_b | output | 32 | Source B register value |
| ext_result | input | 32 | Result of external operations |
| res_valid | output | 1 | Result strobe |
| res_data | output | 32 | Computed result |
| res_dest | output | 3 | Destination register |
| res_mode | output | 3 | Assignment mode field |

## Verification
The result strobe of an instruction appears, without registering, in the cycle it executes. The first instruction executes two cycles after the start edge. Faults show on `err` one cycle after the faulting instruction, and `done` comes one cycle after the last delay slot. A run of N executed instructions therefore ends at exactly cycle N+2 after start. The bench samples every output on the falling edge and logs strobes in the cycle they occur. It compares the whole trace and the ending cycle with a reference model that executes the same program.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEQ_DW    = 32;
  localparam int SEQ_NREG  = 8;
  localparam int SEQ_RAW   = $clog2(SEQ_NREG);
  localparam int SEQ_IMM_W = 18;

  typedef enum logic [2:0] {
    OP_EXT0   = 3'd0,
    OP_ADDI   = 3'd1,
    OP_EXT2   = 3'd2,
    OP_EXT3   = 3'd3,
    OP_RDI    = 3'd4,
    OP_EXT5   = 3'd5,
    OP_BAD    = 3'd6,
    OP_BRANCH = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [SEQ_DW-1:0]  word,
  output op_e                op,
  output logic               ex,
  output logic [2:0]         mode,
  output logic [SEQ_RAW-1:0] dest,
  output logic [SEQ_RAW-1:0] srca,
  output logic [SEQ_RAW-1:0] srcb,
  output logic [SEQ_DW-1:0]  imm_sx,
  output logic               is_branch,
  output logic               is_bad,
  output logic               is_ext
);
  localparam int IMM_LO = SEQ_DW - SEQ_IMM_W;

  always_comb begin
    op     = op_e'(word[2:0]);
    ex     = word[3];
    mode   = word[6:4];
    dest   = word[9:7];
    srca   = word[12:10];
    srcb   = word[15:13];
    imm_sx = {{IMM_LO{word[SEQ_DW-1]}}, word[SEQ_DW-1:IMM_LO]};
    is_branch = (op == OP_BRANCH);
    is_bad    = (op == OP_BAD);
    is_ext    = (op == OP_EXT0) || (op == OP_EXT2) ||
                (op == OP_EXT3) || (op == OP_EXT5);
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] ent_q [NREG];
  logic          wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ent_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NREG; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[waddr] <= wdata;
    end
  end

  assign rdata_a = ent_q[raddr_a];
  assign rdata_b = ent_q[raddr_b];
endmodule

// File: rtl/seq_branch.sv
module seq_branch #(
  parameter int PC_W = 6
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] offset,
  input  logic [31:0]     value,
  input  logic            on_nonzero,
  output logic            taken,
  output logic [PC_W-1:0] target
);
  logic is_zero;

  assign is_zero = (value == 32'd0);
  assign taken   = on_nonzero ? !is_zero : is_zero;
  assign target  = pc + offset;
endmodule

// File: rtl/seq_macro_core.sv
module seq_macro_core
  import seq_pkg::*;
#(
  parameter int PC_W    = 6,
  parameter int SREG_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PC_W-1:0]    start_pc,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               ctx_clear,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [31:0]        imem_data,
  input  logic [31:0]        arg_data,
  output logic               arg_pop,
  output logic [SREG_AW-1:0] sreg_addr,
  input  logic [31:0]        sreg_data,
  output logic [31:0]        op_a,
  output logic [31:0]        op_b,
  input  logic [31:0]        ext_result,
  output logic               res_valid,
  output logic [31:0]        res_data,
  output logic [2:0]         res_dest,
  output logic [2:0]         res_mode
);
  localparam logic [PC_W-1:0]    PC_STEP = PC_W'(1);
  localparam logic [SEQ_RAW-1:0] ARG_REG = SEQ_RAW'(1);

  seq_state_e st_q, st_n;
  logic [PC_W-1:0] pc_q, pc_n, tgt_q, tgt_n;
  logic slot_q, slot_n, exitp_q, exitp_n;
  logic done_q, done_n, err_q, err_n;

  op_e                op;
  logic               ex, is_branch, is_bad, is_ext;
  logic [2:0]         mode;
  logic [SEQ_RAW-1:0] dest, srca, srcb;
  logic [31:0]        imm_sx;

  logic               run, load, exec, fetch_mode;
  logic               br_taken;
  logic [PC_W-1:0]    br_target, pc_inc;
  logic [31:0]        result;
  logic               rf_we, rf_clr;
  logic [SEQ_RAW-1:0] rf_waddr;
  logic [31:0]        rf_wdata;

  seq_decode u_dec (
    .word(imem_data), .op(op), .ex(ex), .mode(mode), .dest(dest),
    .srca(srca), .srcb(srcb), .imm_sx(imm_sx), .is_branch(is_branch),
    .is_bad(is_bad), .is_ext(is_ext)
  );

  seq_regfile #(.NREG(SEQ_NREG), .DW(SEQ_DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(rf_clr), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .raddr_a(srca), .raddr_b(srcb),
    .rdata_a(op_a), .rdata_b(op_b)
  );

  seq_branch #(.PC_W(PC_W)) u_br (
    .pc(pc_q), .offset(imm_sx[PC_W-1:0]), .value(op_a),
    .on_nonzero(mode[0]), .taken(br_taken), .target(br_target)
  );

  assign run        = (st_q == ST_RUN);
  assign load       = (st_q == ST_LOAD);
  assign exec       = run && !is_branch && !is_bad;
  assign fetch_mode = (mode == 3'd0);
  assign pc_inc     = pc_q + PC_STEP;

  // result selection for executed instructions
  always_comb begin
    if (op == OP_ADDI)     result = op_a + imm_sx;
    else if (op == OP_RDI) result = sreg_data;
    else if (is_ext)       result = ext_result;
    else                   result = '0;
  end

  // register file write port: preload in load, destination in run
  always_comb begin
    rf_clr   = (st_q == ST_IDLE) && start;
    rf_we    = 1'b0;
    rf_waddr = dest;
    rf_wdata = result;
    if (load) begin
      rf_we    = 1'b1;
      rf_waddr = ARG_REG;
      rf_wdata = arg_data;
    end else if (exec) begin
      rf_we    = 1'b1;
      rf_wdata = fetch_mode ? arg_data : result;
    end
  end

  // next-state logic
  always_comb begin
    st_n    = st_q;
    pc_n    = pc_q;
    tgt_n   = tgt_q;
    slot_n  = slot_q;
    exitp_n = exitp_q;
    err_n   = err_q;
    done_n  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n    = ST_LOAD;
          pc_n    = start_pc;
          slot_n  = 1'b0;
          exitp_n = 1'b0;
          err_n   = 1'b0;
        end
      end
      ST_LOAD: st_n = ST_RUN;
      ST_RUN: begin
        if (is_bad || (is_branch && slot_q)) begin
          err_n   = 1'b1;
          st_n    = ST_IDLE;
          slot_n  = 1'b0;
          exitp_n = 1'b0;
        end else if (is_branch && br_taken) begin
          if (mode[1]) begin
            pc_n = br_target;
          end else begin
            pc_n   = pc_inc;
            tgt_n  = br_target;
            slot_n = 1'b1;
          end
        end else if (slot_q) begin
          slot_n = 1'b0;
          if (exitp_q) begin
            exitp_n = 1'b0;
            done_n  = 1'b1;
            st_n    = ST_IDLE;
          end else begin
            pc_n = tgt_q;
          end
        end else if (ex) begin
          slot_n  = 1'b1;
          exitp_n = 1'b1;
          pc_n    = pc_inc;
        end else begin
          pc_n = pc_inc;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pc_q    <= '0;
      tgt_q   <= '0;
      slot_q  <= 1'b0;
      exitp_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      pc_q    <= pc_n;
      tgt_q   <= tgt_n;
      slot_q  <= slot_n;
      exitp_q <= exitp_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign ctx_clear = load;
  assign imem_addr = pc_q;
  assign arg_pop   = load || (exec && fetch_mode);
  assign sreg_addr = op_a[SREG_AW-1:0] + imm_sx[SREG_AW-1:0];
  assign res_valid = exec;
  assign res_data  = result;
  assign res_dest  = dest;
  assign res_mode  = mode;
endmodule

// File: rtl/seq_macro_core_chk.sv
module seq_macro_core_chk #(
  parameter int SREG_AW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        ctx_clear,
  input logic [31:0] imem_data,
  input logic        arg_pop,
  input logic [31:0] sreg_data,
  input logic [31:0] op_a,
  input logic [31:0] ext_result,
  input logic        res_valid,
  input logic [31:0] res_data,
  input logic [2:0]  res_mode
);
  logic running;
  logic [2:0] opc;
  assign running = busy && !ctx_clear;
  assign opc     = imem_data[2:0];

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !res_valid && !ctx_clear);

  a_r2_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |=> !ctx_clear && busy);

  a_r3_r0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    running && imem_data[12:10] == 3'd0 |-> op_a == 32'd0);

  a_r5_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && opc == 3'd4 |-> res_data == sreg_data);

  a_r8_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !done);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err);

  a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    running && opc == 3'd6 |=> err && !busy);

  a_r11_fetch_pops: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_mode == 3'd0 |-> arg_pop);

  a_r12_ext_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (opc == 3'd0 || opc == 3'd2 || opc == 3'd3 || opc == 3'd5)
    |-> res_data == ext_result);
endmodule

bind seq_macro_core seq_macro_core_chk #(.SREG_AW(SREG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .ctx_clear(ctx_clear), .imem_data(imem_data), .arg_pop(arg_pop),
  .sreg_data(sreg_data), .op_a(op_a), .ext_result(ext_result),
  .res_valid(res_valid), .res_data(res_data), .res_mode(res_mode)
);

// File: tb/seq_macro_core_tb.sv
module seq_macro_core_tb;
  localparam int CLK_P = 10;
  localparam int PC_W = 6;
  localparam int SREG_AW = 6;
  localparam int MEM_N = 1 << PC_W;
  localparam logic [31:0] EXT_K = 32'h1234_5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PC_W-1:0] start_pc = '0;
  logic busy, done, err, ctx_clear, arg_pop, res_valid;
  logic [PC_W-1:0] imem_addr;
  logic [SREG_AW-1:0] sreg_addr;
  logic [31:0] imem_data, arg_data, sreg_data, op_a, op_b, ext_result, res_data;
  logic [2:0] res_dest, res_mode;

  logic [31:0] imem [MEM_N];
  logic [31:0] args [64];
  logic [31:0] sregs [1 << SREG_AW];
  int aptr = 0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  assign imem_data  = imem[imem_addr];
  assign arg_data   = args[aptr[5:0]];
  assign sreg_data  = sregs[sreg_addr];
  assign ext_result = op_a ^ (op_b + EXT_K);

  always @(posedge clk) if (arg_pop) aptr <= aptr + 1;

  seq_macro_core #(.PC_W(PC_W), .SREG_AW(SREG_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc), .busy(busy),
    .done(done), .err(err), .ctx_clear(ctx_clear), .imem_addr(imem_addr),
    .imem_data(imem_data), .arg_data(arg_data), .arg_pop(arg_pop),
    .sreg_addr(sreg_addr), .sreg_data(sreg_data), .op_a(op_a), .op_b(op_b),
    .ext_result(ext_result), .res_valid(res_valid), .res_data(res_data),
    .res_dest(res_dest), .res_mode(res_mode)
  );

  // expected trace from reference model
  logic [31:0] e_data [256];
  int e_dest [256];
  int e_mode [256];
  int e_n, e_steps;
  bit e_err, e_hung;
  // observed trace
  logic [31:0] o_data [256];
  int o_dest [256];
  int o_mode [256];
  int o_n, o_cyc, o_clr;
  bit o_err, o_done;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] wi(int op, bit ex, int md, int ds, int sa, int imm);
    return {18'(imm), 1'b0, 3'(sa), 3'(ds), 3'(md), ex, 3'(op)};
  endfunction

  function automatic logic [31:0] wr(int op, bit ex, int md, int ds, int sa, int sb);
    return {16'd0, 3'(sb), 3'(sa), 3'(ds), 3'(md), ex, 3'(op)};
  endfunction

  function automatic logic [31:0] wb(bit nonzero, bit nodelay, int sa, int imm);
    return wi(7, 1'b0, (nodelay ? 2 : 0) + (nonzero ? 1 : 0), 0, sa, imm);
  endfunction

  task automatic ref_run(input int off);
    logic [31:0] r [8];
    logic [31:0] w, v, res, val;
    int ap, pc, tgt, op, md, ds, sa, sb, imm;
    bit slot, exitp, adv, tk;
    for (int i = 0; i < 8; i++) r[i] = '0;
    r[1] = args[0]; ap = 1; pc = off; slot = 0; exitp = 0; tgt = 0;
    e_n = 0; e_steps = 0; e_err = 0; e_hung = 1;
    for (int s = 0; s < 200; s++) begin
      w = imem[pc]; e_steps++;
      op = int'(w[2:0]); md = int'(w[6:4]); ds = int'(w[9:7]);
      sa = int'(w[12:10]); sb = int'(w[15:13]); imm = int'($signed(w[31:14]));
      adv = 1;
      if (op == 7) begin
        if (slot) begin e_err = 1; e_hung = 0; return; end
        v = r[sa];
        tk = md[0] ? (v != 0) : (v == 0);
        if (tk) begin
          adv = 0;
          if (md[1]) pc = (pc + imm) & (MEM_N - 1);
          else begin tgt = (pc + imm) & (MEM_N - 1); pc = (pc + 1) & (MEM_N - 1); slot = 1; end
        end
      end else if (op == 6) begin
        e_err = 1; e_hung = 0; return;
      end else begin
        if (op == 1)      res = r[sa] + 32'(imm);
        else if (op == 4) res = sregs[(r[sa] + 32'(imm)) & 32'(MEM_N - 1)];
        else              res = r[sa] ^ (r[sb] + EXT_K);
        if (md == 0) begin val = args[ap]; ap++; end else val = res;
        e_data[e_n] = res; e_dest[e_n] = ds; e_mode[e_n] = md; e_n++;
        if (ds != 0) r[ds] = val;
      end
      if (adv) begin
        if (slot) begin
          if (exitp) begin e_hung = 0; return; end
          pc = tgt; slot = 0;
        end else if (w[3]) begin
          slot = 1; exitp = 1; pc = (pc + 1) & (MEM_N - 1);
        end else pc = (pc + 1) & (MEM_N - 1);
      end
    end
  endtask

  task automatic run_prog(input int off, input string tag, input int restart_at);
    ref_run(off);
    aptr = 0; o_n = 0; o_clr = 0;
    start_pc = PC_W'(off); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    o_cyc = 1;
    while (1) begin
      if (ctx_clear) o_clr++;
      if (res_valid && o_n < 256) begin
        o_data[o_n] = res_data; o_dest[o_n] = int'(res_dest);
        o_mode[o_n] = int'(res_mode); o_n++;
      end
      if (done || err || o_cyc > 400) break;
      start = (o_cyc == restart_at);
      @(negedge clk);
      o_cyc++;
    end
    start = 1'b0;
    o_err = err; o_done = done;
    if (!e_hung) begin
      check(o_err == e_err, e_err ? "R8" : "R9", {tag, " outcome err"}, o_err, e_err);
      check(o_done == !e_err, "R9", {tag, " done at end"}, o_done, !e_err);
      check(o_cyc == e_steps + 2, "R9", {tag, " end cycle"}, o_cyc, e_steps + 2);
      check(o_clr == 1, "R2", {tag, " ctx_clear cycles"}, o_clr, 1);
      check(o_n == e_n, "R12", {tag, " strobe count"}, o_n, e_n);
      for (int i = 0; i < e_n && i < o_n; i++) begin
        if (o_data[i] != e_data[i] || o_dest[i] != e_dest[i] || o_mode[i] != e_mode[i]) begin
          check(1'b0, "R4", {tag, " strobe data mismatch"}, o_data[i], e_data[i]);
          break;
        end
      end
    end
    @(negedge clk);
    check(!done && !busy, "R9", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic fill_exit();
    for (int i = 0; i < MEM_N; i++) imem[i] = wi(1, 1'b1, 1, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) args[i] = $urandom;
    for (int i = 0; i < (1 << SREG_AW); i++) sregs[i] = $urandom;
    fill_exit();
    #(CLK_P * 3);
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && !err && !ctx_clear && !res_valid, "R1", "reset outputs",
          {busy, done, err, ctx_clear, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err, "R1", "after reset release", {busy, done, err}, 0);

    // R2 R3 R4: preload, r0 discard, negative immediate
    fill_exit();
    imem[0] = wi(1, 0, 1, 0, 1, -3);
    imem[1] = wi(1, 1, 1, 5, 0, 9);
    imem[2] = wi(1, 0, 1, 2, 1, 0);
    run_prog(0, "R2 preload", 0);
    check(o_data[0] == args[0] - 32'd3, "R4", "negative immediate", o_data[0], args[0] - 32'd3);
    check(o_data[1] == 32'd9, "R3", "r0 after discarded write", o_data[1], 9);
    check(o_data[2] == args[0], "R2", "r1 preload", o_data[2], args[0]);
    // R2: registers cleared by the next start
    fill_exit();
    imem[0] = wi(1, 1, 1, 3, 2, 0);
    imem[1] = wi(1, 0, 1, 6, 5, 1);
    run_prog(0, "R2 clear", 0);
    check(o_data[0] == 0 && o_data[1] == 1, "R2", "registers cleared", o_data[0], 0);

    // R7: delayed branch executes slot then target
    fill_exit();
    imem[0] = wi(1, 0, 1, 2, 0, 0);
    imem[1] = wb(0, 0, 2, 3);
    imem[2] = wi(1, 0, 1, 3, 0, 11);
    imem[3] = wi(1, 0, 1, 4, 0, 22);
    imem[4] = wi(1, 1, 1, 5, 0, 33);
    imem[5] = wi(1, 0, 1, 6, 0, 44);
    run_prog(0, "R7 delayed", 0);
    check(o_n == 4 && o_data[1] == 11 && o_data[2] == 33, "R7", "delay slot then target", o_data[2], 33);
    // R13: start while busy ignored, same program
    run_prog(0, "R13 restart", 3);
    check(o_n == 4 && o_data[3] == 44, "R13", "restart ignored", o_data[3], 44);
    // R7: no-delay jump skips the next instruction
    imem[1] = wb(0, 1, 2, 3);
    run_prog(0, "R7 nodelay", 0);
    check(o_n == 3 && o_data[1] == 33, "R7", "no delay jump", o_data[1], 33);

    // R6: backward branch on non-zero forms a loop
    fill_exit();
    imem[0] = wi(1, 0, 1, 2, 0, 3);
    imem[1] = wi(1, 0, 1, 2, 2, -1);
    imem[2] = wb(1, 1, 2, -1);
    imem[3] = wi(1, 1, 1, 7, 2, 0);
    imem[4] = wi(1, 0, 1, 7, 7, 5);
    run_prog(0, "R6 loop", 0);
    check(o_n == 6 && o_data[5] == 5, "R6", "backward loop", o_n, 6);
    // R6: zero test not taken on a non-zero register
    fill_exit();
    imem[0] = wb(0, 1, 1, 5);
    imem[1] = wi(1, 1, 1, 3, 0, 12);
    imem[2] = wi(1, 0, 1, 4, 0, 13);
    args[0] = 32'h55;
    run_prog(0, "R6 not taken", 0);
    check(o_n == 2 && o_data[0] == 12, "R6", "fall through", o_data[0], 12);

    // R8: branch inside a delay slot faults
    fill_exit();
    imem[0] = wb(0, 0, 0, 5);
    imem[1] = wb(1, 0, 0, 2);
    run_prog(0, "R8 slot branch", 0);
    check(o_err && o_n == 0, "R8", "fault flag", o_err, 1);

    // R10: unknown opcode
    fill_exit();
    imem[0] = wi(1, 0, 1, 2, 0, 1);
    imem[1] = wi(6, 0, 1, 2, 0, 0);
    run_prog(0, "R10 bad op", 0);
    check(o_err && o_cyc == 4, "R10", "unknown opcode fault", o_cyc, 4);

    // R9: exit inside a delay slot has no effect
    fill_exit();
    imem[0] = wb(0, 0, 0, 3);
    imem[1] = wi(1, 1, 1, 2, 0, 1);
    imem[2] = wi(1, 0, 1, 3, 0, 2);
    imem[3] = wi(1, 1, 1, 4, 0, 4);
    imem[4] = wi(1, 0, 1, 5, 0, 5);
    run_prog(0, "R9 slot exit", 0);
    check(o_n == 3 && o_data[1] == 4, "R9", "slot exit ignored", o_data[1], 4);

    // R11: fetch mode writes the argument
    fill_exit();
    imem[0] = wi(1, 1, 0, 2, 0, 7);
    imem[1] = wi(1, 0, 1, 3, 2, 0);
    run_prog(0, "R11 fetch", 0);
    check(o_data[0] == 7 && o_data[1] == args[1], "R11", "fetched argument", o_data[1], args[1]);

    // R5 R12: read-immediate and external operation
    fill_exit();
    imem[0] = wi(1, 0, 1, 2, 0, 10);
    imem[1] = wi(4, 0, 1, 3, 2, 5);
    imem[2] = wr(0, 1, 1, 4, 1, 3);
    run_prog(0, "R5 read", 0);
    check(o_data[1] == sregs[15], "R5", "state read", o_data[1], sregs[15]);
    check(o_data[2] == (args[0] ^ (sregs[15] + EXT_K)), "R12", "external result",
          o_data[2], args[0] ^ (sregs[15] + EXT_K));

    // random programs
    for (int t = 0; t < 40; t++) begin
      int off;
      fill_exit();
      off = int'($urandom % 40);
      for (int k = 0; k < 16; k++) begin
        int sel, md;
        logic [31:0] w;
        sel = int'($urandom % 16);
        md = int'($urandom % 8);
        w = $urandom;
        if (sel < 4 || sel > 13)
          w = wi(1, 1'b0, md, int'(w[9:7]), int'(w[12:10]), int'($signed(w[31:14])));
        else if (sel < 6)
          w = wi(4, 1'b0, md, int'(w[9:7]), int'(w[12:10]), int'(w[20:14]));
        else if (sel < 9) begin
          int ops [4] = '{0, 2, 3, 5};
          w = wr(ops[w[1:0]], 1'b0, md, int'(w[9:7]), int'(w[12:10]), int'(w[15:13]));
        end else if (sel < 12)
          w = wb(w[4], w[5], int'(w[12:10]), 1 + int'($urandom % 4));
        else if (sel == 12)
          w = wi(1, 1'b1, md, int'(w[9:7]), int'(w[12:10]), int'(w[20:14]));
        else
          w = ($urandom % 4 == 0) ? wi(6, 0, 0, 0, 0, 0) : wi(1, 0, md, 1, 1, 1);
        imem[off + k] = w;
      end
      args[0] = $urandom;
      run_prog(off, "R12 random", ($urandom % 2 == 0) ? 4 : 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule